// File: doc/BRIEF.md
# Privileged Trap Entry Controller

This block takes a processor into a trap handler across three privilege levels (user, supervisor, machine). When a trap request arrives, it looks at the current privilege and at two per-code delegation masks and picks the handler level. In the cycle the request is accepted it does all of the following:

- writes that level's cause, return-address and trap-information registers;
- saves and clears that level's interrupt-enable state in the status word;
- switches the privilege;
- captures the handler's vector base, with its two low mode bits cleared, as the fetch redirect target.

A synchronous active-low reset forces a defined state and redirects fetch to a fixed reset vector.

A small sequencer with three named states handles the redirects:

- `SEQ_BOOT` is held during reset and for the first cycle after it. It drives the reset vector and always moves to `SEQ_IDLE`.
- `SEQ_IDLE` accepts a trap request, which moves it to `SEQ_REDIR`. With no request it stays in `SEQ_IDLE`.
- `SEQ_REDIR` drives the one-cycle redirect pulse and always returns to `SEQ_IDLE`.

The enclosing processor uses the context-load port to restore privilege and status on return from a trap, and to prepare state before traps.

Top module: `trap_entry_ctrl`

## Requirements
- R1: The handler privilege is machine by default. When the current privilege is not machine and bit `trap_code` of `mach_deleg` is 1, the handler is supervisor.
- R2: When the current privilege is user and bit `trap_code` of `sup_deleg` is 1, the handler is user. This applies whatever the `mach_deleg` bit is.
- R3: The handler level's cause register receives `trap_is_irq` in bit XLEN-1 and `trap_code` in bits 4:0, with zeros in between.
- R4: The handler level's return-address register receives `trap_pc` and its trap-information register receives `trap_val`. The cause, return-address and trap-information registers of the other two levels keep their values.
- R5: The status word has these bit positions: uie[0], sie[1], mie[2], upie[3], spie[4], mpie[5], spp[6], mpp[8:7], mprv[9]. A user handler sets upie to the old uie and clears uie; all other status bits keep their values.
- R6: A supervisor handler sets spp to bit 0 of the prior privilege, sets spie to the old sie and clears sie. All other status bits keep their values.
- R7: A machine handler sets mpp to the prior privilege, sets mpie to the old mie and clears mie. All other status bits keep their values.
- R8: After a trap, `cur_priv` shows the handler level, encoded as user = 0, supervisor = 1, machine = 3. The value 2 never appears.
- R9: After the edge that accepts a trap, `redirect_valid` is 1 for exactly one cycle. During that cycle `redirect_pc` equals the handler level's base input as sampled at the trap edge, with bits 1:0 forced to zero.
- R10: While reset is held, the privilege is machine, the whole status word (including mie and mprv) is zero, and all nine level registers (including the machine cause) are zero. During reset and the first cycle after its release, `redirect_valid` is 1 and `redirect_pc` equals `RESET_VEC`.
- R11: A trap request during a redirect cycle is ignored. It changes no register, status bit or privilege, and it produces no further redirect.
- R12: On an edge with no accepted trap, `ctx_load` loads `ctx_status` into the status word and `ctx_priv` into the privilege. A `ctx_priv` of 2 leaves the privilege unchanged. An accepted trap on the same edge takes precedence over the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_req | input | 1 | Trap request |
| trap_code | input | 5 | Exception or interrupt code |
| trap_is_irq | input | 1 | Request is an interrupt |
| trap_pc | input | XLEN | Address of the trapping instruction |
| trap_val | input | XLEN | Trap information value |
| mach_deleg | input | 32 | Per-code delegation from machine to supervisor |
| sup_deleg | input | 32 | Per-code delegation from supervisor to user |
| user_base | input | XLEN | User handler vector base |
| sup_base | input | XLEN | Supervisor handler vector base |
| mach_base | input | XLEN | Machine handler vector base |
| ctx_load | input | 1 | Load privilege and status |
| ctx_priv | input | 2 | Privilege to load |
| ctx_status | input | 10 | Status word to load |
| cur_priv | output | 2 | Current privilege |
| status | output | 10 | Status word |
| user_cause | output | XLEN | User cause register |
| user_ret_pc | output | XLEN | User return address |
| user_tinfo | output | XLEN | User trap information |
| sup_cause | output | XLEN | Supervisor cause register |
| sup_ret_pc | output | XLEN | Supervisor return address |
| sup_tinfo | output | XLEN | Supervisor trap information |
| mach_cause | output | XLEN | Machine cause register |
| mach_ret_pc | output | XLEN | Machine return address |
| mach_tinfo | output | XLEN | Machine trap information |
| redirect_valid | output | 1 | Fetch redirect strobe |
| redirect_pc | output | XLEN | Fetch redirect target |

## Verification
The level registers, status word and privilege go through one register stage, so they show a trap or a context load in the cycle right after the edge that accepted it. The redirect pulse and target come out of the sequencer state in that same cycle, and the pulse has dropped again one edge later. The bench drives every input one time unit after a rising edge and samples all outputs one time unit after the following rising edge. Each check therefore sees exactly the edge that should have produced its result. The reset-vector redirect is checked before the first edge after release.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

    localparam int CODE_W  = 5;
    localparam int MASK_W  = 1 << CODE_W;
    localparam int NUM_LVL = 3;

    localparam int LVL_U = 0;
    localparam int LVL_S = 1;
    localparam int LVL_M = 2;

    typedef enum logic [1:0] {
        PRIV_U    = 2'd0,
        PRIV_S    = 2'd1,
        PRIV_RSVD = 2'd2,
        PRIV_M    = 2'd3
    } priv_e;

    // packed MSB first: mprv is bit 9, uie is bit 0
    typedef struct packed {
        logic       mprv;
        logic [1:0] mpp;
        logic       spp;
        logic       mpie;
        logic       spie;
        logic       upie;
        logic       mie;
        logic       sie;
        logic       uie;
    } stat_t;

    localparam int STAT_W = $bits(stat_t);

    typedef enum logic [1:0] {
        SEQ_BOOT  = 2'd0,
        SEQ_IDLE  = 2'd1,
        SEQ_REDIR = 2'd2
    } seq_e;

endpackage

// File: rtl/trap_deleg_sel.sv
module trap_deleg_sel
    import trap_entry_pkg::*;
#(
    parameter int CW = CODE_W,
    localparam int MW = 1 << CW
) (
    input  priv_e          cur_priv,
    input  logic [CW-1:0]  code,
    input  logic [MW-1:0]  m_mask,
    input  logic [MW-1:0]  s_mask,
    output priv_e          hnd_priv
);

    logic to_sup;
    logic to_user;

    always_comb begin
        to_sup  = (cur_priv != PRIV_M) && m_mask[code];
        to_user = (cur_priv == PRIV_U) && s_mask[code];
    end

    // second stage overrides the first
    always_comb begin
        hnd_priv = PRIV_M;
        if (to_sup) begin
            hnd_priv = PRIV_S;
        end
        if (to_user) begin
            hnd_priv = PRIV_U;
        end
    end

endmodule

// File: rtl/trap_status_upd.sv
module trap_status_upd
    import trap_entry_pkg::*;
(
    input  stat_t old_stat,
    input  priv_e prior_priv,
    input  priv_e hnd_priv,
    output stat_t new_stat
);

    always_comb begin
        new_stat = old_stat;
        unique case (hnd_priv)
            PRIV_U: begin
                new_stat.upie = old_stat.uie;
                new_stat.uie  = 1'b0;
            end
            PRIV_S: begin
                new_stat.spp  = prior_priv[0];
                new_stat.spie = old_stat.sie;
                new_stat.sie  = 1'b0;
            end
            PRIV_M: begin
                new_stat.mpp  = prior_priv;
                new_stat.mpie = old_stat.mie;
                new_stat.mie  = 1'b0;
            end
            default: begin
                new_stat = old_stat;
            end
        endcase
    end

endmodule

// File: rtl/trap_level_bank.sv
module trap_level_bank
    import trap_entry_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NL   = NUM_LVL
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NL-1:0]           wr_sel,
    input  logic [XLEN-1:0]         cause_d,
    input  logic [XLEN-1:0]         ret_d,
    input  logic [XLEN-1:0]         info_d,
    output logic [NL-1:0][XLEN-1:0] cause_q,
    output logic [NL-1:0][XLEN-1:0] ret_q,
    output logic [NL-1:0][XLEN-1:0] info_q
);

    for (genvar g = 0; g < NL; g++) begin : g_lvl
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cause_q[g] <= '0;
                ret_q[g]   <= '0;
                info_q[g]  <= '0;
            end else if (wr_sel[g]) begin
                cause_q[g] <= cause_d;
                ret_q[g]   <= ret_d;
                info_q[g]  <= info_d;
            end
        end
    end

endmodule

// File: rtl/trap_seq_fsm.sv
module trap_seq_fsm
    import trap_entry_pkg::*;
#(
    parameter int              XLEN   = 32,
    parameter logic [XLEN-1:0] RST_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap_req,
    input  logic [XLEN-1:0] vec_base,
    output logic            take,
    output logic            redirect_valid,
    output logic [XLEN-1:0] redirect_pc
);

    seq_e            st_q;
    seq_e            st_d;
    logic [XLEN-1:0] tgt_q;

    always_comb begin
        take = (st_q == SEQ_IDLE) && trap_req;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SEQ_BOOT:  st_d = SEQ_IDLE;
            SEQ_IDLE:  st_d = trap_req ? SEQ_REDIR : SEQ_IDLE;
            SEQ_REDIR: st_d = SEQ_IDLE;
            default:   st_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= SEQ_BOOT;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q <= '0;
        end else if (take) begin
            tgt_q <= {vec_base[XLEN-1:2], 2'b00};
        end
    end

    always_comb begin
        unique case (st_q)
            SEQ_BOOT: begin
                redirect_valid = 1'b1;
                redirect_pc    = RST_PC;
            end
            SEQ_REDIR: begin
                redirect_valid = 1'b1;
                redirect_pc    = tgt_q;
            end
            default: begin
                redirect_valid = 1'b0;
                redirect_pc    = tgt_q;
            end
        endcase
    end

endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
    import trap_entry_pkg::*;
#(
    parameter int          XLEN      = 32,
    parameter logic [63:0] RESET_VEC = 64'h0000_0000_0000_0200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_req,
    input  logic [CODE_W-1:0] trap_code,
    input  logic              trap_is_irq,
    input  logic [XLEN-1:0]   trap_pc,
    input  logic [XLEN-1:0]   trap_val,
    input  logic [MASK_W-1:0] mach_deleg,
    input  logic [MASK_W-1:0] sup_deleg,
    input  logic [XLEN-1:0]   user_base,
    input  logic [XLEN-1:0]   sup_base,
    input  logic [XLEN-1:0]   mach_base,
    input  logic              ctx_load,
    input  logic [1:0]        ctx_priv,
    input  logic [STAT_W-1:0] ctx_status,
    output logic [1:0]        cur_priv,
    output logic [STAT_W-1:0] status,
    output logic [XLEN-1:0]   user_cause,
    output logic [XLEN-1:0]   user_ret_pc,
    output logic [XLEN-1:0]   user_tinfo,
    output logic [XLEN-1:0]   sup_cause,
    output logic [XLEN-1:0]   sup_ret_pc,
    output logic [XLEN-1:0]   sup_tinfo,
    output logic [XLEN-1:0]   mach_cause,
    output logic [XLEN-1:0]   mach_ret_pc,
    output logic [XLEN-1:0]   mach_tinfo,
    output logic              redirect_valid,
    output logic [XLEN-1:0]   redirect_pc
);

    localparam logic [XLEN-1:0] RST_PC = RESET_VEC[XLEN-1:0];

    priv_e                        priv_q;
    stat_t                        stat_q;
    priv_e                        hnd_priv;
    stat_t                        stat_trap;
    logic                         take_trap;
    logic [XLEN-1:0]              cause_d;
    logic [XLEN-1:0]              vec_sel;
    logic [NUM_LVL-1:0]           wr_sel;
    logic [NUM_LVL-1:0][XLEN-1:0] cause_q;
    logic [NUM_LVL-1:0][XLEN-1:0] ret_q;
    logic [NUM_LVL-1:0][XLEN-1:0] info_q;

    trap_deleg_sel #(.CW(CODE_W)) u_deleg (
        .cur_priv (priv_q),
        .code     (trap_code),
        .m_mask   (mach_deleg),
        .s_mask   (sup_deleg),
        .hnd_priv (hnd_priv)
    );

    trap_status_upd u_stat (
        .old_stat   (stat_q),
        .prior_priv (priv_q),
        .hnd_priv   (hnd_priv),
        .new_stat   (stat_trap)
    );

    always_comb begin
        cause_d              = '0;
        cause_d[CODE_W-1:0]  = trap_code;
        cause_d[XLEN-1]      = trap_is_irq;
    end

    always_comb begin
        wr_sel  = '0;
        vec_sel = mach_base;
        unique case (hnd_priv)
            PRIV_U: begin
                wr_sel[LVL_U] = take_trap;
                vec_sel       = user_base;
            end
            PRIV_S: begin
                wr_sel[LVL_S] = take_trap;
                vec_sel       = sup_base;
            end
            default: begin
                wr_sel[LVL_M] = take_trap;
                vec_sel       = mach_base;
            end
        endcase
    end

    trap_level_bank #(.XLEN(XLEN), .NL(NUM_LVL)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_sel  (wr_sel),
        .cause_d (cause_d),
        .ret_d   (trap_pc),
        .info_d  (trap_val),
        .cause_q (cause_q),
        .ret_q   (ret_q),
        .info_q  (info_q)
    );

    trap_seq_fsm #(.XLEN(XLEN), .RST_PC(RST_PC)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .trap_req       (trap_req),
        .vec_base       (vec_sel),
        .take           (take_trap),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            priv_q <= PRIV_M;
        end else if (take_trap) begin
            priv_q <= hnd_priv;
        end else if (ctx_load && (ctx_priv != PRIV_RSVD)) begin
            priv_q <= priv_e'(ctx_priv);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else if (take_trap) begin
            stat_q <= stat_trap;
        end else if (ctx_load) begin
            stat_q <= stat_t'(ctx_status);
        end
    end

    always_comb begin
        cur_priv    = priv_q;
        status      = stat_q;
        user_cause  = cause_q[LVL_U];
        user_ret_pc = ret_q[LVL_U];
        user_tinfo  = info_q[LVL_U];
        sup_cause   = cause_q[LVL_S];
        sup_ret_pc  = ret_q[LVL_S];
        sup_tinfo   = info_q[LVL_S];
        mach_cause  = cause_q[LVL_M];
        mach_ret_pc = ret_q[LVL_M];
        mach_tinfo  = info_q[LVL_M];
    end

endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            take,
    input logic            trap_req,
    input logic [1:0]      hnd,
    input logic [1:0]      cur_priv,
    input logic [9:0]      status,
    input logic            trap_is_irq,
    input logic [XLEN-1:0] mach_cause,
    input logic            redirect_valid
);

    // R7
    mpp_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && hnd == 2'd3) |=> (status[8:7] == $past(cur_priv)));

    // R5 R6 R7
    ie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> ((($past(hnd) == 2'd0) && !status[0]) ||
                  (($past(hnd) == 2'd1) && !status[1]) ||
                  (($past(hnd) == 2'd3) && !status[2])));

    // R3
    cause_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && hnd == 2'd3) |=> (mach_cause[XLEN-1] == $past(trap_is_irq)));

    // R1
    mach_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cur_priv == 2'd3) |=> (cur_priv == 2'd3));

    // R8
    priv_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_priv != 2'd2);

    // R9
    redir_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> redirect_valid);

    // R9
    redir_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> !redirect_valid);

    // R11
    redir_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_valid && trap_req) |-> !take);

endmodule

bind trap_entry_ctrl trap_entry_chk #(.XLEN(XLEN)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .take           (take_trap),
    .trap_req       (trap_req),
    .hnd            (hnd_priv),
    .cur_priv       (cur_priv),
    .status         (status),
    .trap_is_irq    (trap_is_irq),
    .mach_cause     (mach_cause),
    .redirect_valid (redirect_valid)
);

// File: tb/tb_trap_entry_ctrl.sv
module tb_trap_entry_ctrl;

    localparam int          CLK_PERIOD = 10;
    localparam int          XL         = 32;
    localparam logic [31:0] RST_PC     = 32'h0000_0200;
    localparam logic [31:0] UBASE      = 32'h2000_0303;
    localparam logic [31:0] SBASE      = 32'h4000_0202;
    localparam logic [31:0] MBASE      = 32'h8000_0101;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          trap_req;
    logic [4:0]    trap_code;
    logic          trap_is_irq;
    logic [XL-1:0] trap_pc;
    logic [XL-1:0] trap_val;
    logic [31:0]   mach_deleg;
    logic [31:0]   sup_deleg;
    logic          ctx_load;
    logic [1:0]    ctx_priv;
    logic [9:0]    ctx_status;
    logic [1:0]    cur_priv;
    logic [9:0]    status;
    logic [XL-1:0] user_cause, user_ret_pc, user_tinfo;
    logic [XL-1:0] sup_cause, sup_ret_pc, sup_tinfo;
    logic [XL-1:0] mach_cause, mach_ret_pc, mach_tinfo;
    logic          redirect_valid;
    logic [XL-1:0] redirect_pc;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [1:0]  mpv;
    logic [9:0]  mst;
    logic [31:0] mc [3];
    logic [31:0] me [3];
    logic [31:0] mt [3];

    always #(CLK_PERIOD/2) clk = ~clk;

    trap_entry_ctrl #(.XLEN(XL), .RESET_VEC(64'h200)) dut (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_code(trap_code),
        .trap_is_irq(trap_is_irq), .trap_pc(trap_pc), .trap_val(trap_val),
        .mach_deleg(mach_deleg), .sup_deleg(sup_deleg),
        .user_base(UBASE), .sup_base(SBASE), .mach_base(MBASE),
        .ctx_load(ctx_load), .ctx_priv(ctx_priv), .ctx_status(ctx_status),
        .cur_priv(cur_priv), .status(status),
        .user_cause(user_cause), .user_ret_pc(user_ret_pc), .user_tinfo(user_tinfo),
        .sup_cause(sup_cause), .sup_ret_pc(sup_ret_pc), .sup_tinfo(sup_tinfo),
        .mach_cause(mach_cause), .mach_ret_pc(mach_ret_pc), .mach_tinfo(mach_tinfo),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic model_reset();
        mpv = 2'd3;
        mst = '0;
        for (int i = 0; i < 3; i++) begin
            mc[i] = '0; me[i] = '0; mt[i] = '0;
        end
    endtask

    task automatic check_state(input string ptag, input string stag, input string rtag,
                               input logic exp_rv, input logic [31:0] exp_pc);
        chk({ptag, " priv"}, cur_priv, mpv);
        chk({stag, " status"}, status, mst);
        chk({rtag, " user cause"},  user_cause,  mc[0]);
        chk({rtag, " user ret"},    user_ret_pc, me[0]);
        chk({rtag, " user info"},   user_tinfo,  mt[0]);
        chk({rtag, " sup cause"},   sup_cause,   mc[1]);
        chk({rtag, " sup ret"},     sup_ret_pc,  me[1]);
        chk({rtag, " sup info"},    sup_tinfo,   mt[1]);
        chk({rtag, " mach cause"},  mach_cause,  mc[2]);
        chk({rtag, " mach ret"},    mach_ret_pc, me[2]);
        chk({rtag, " mach info"},   mach_tinfo,  mt[2]);
        chk("R9 redirect valid", redirect_valid, exp_rv);
        if (exp_rv) chk("R9 redirect pc", redirect_pc, exp_pc);
    endtask

    // applies a trap to the model; returns the handler privilege and target
    task automatic model_trap(input logic md, input logic sd, input logic [4:0] code,
                              input logic irq, input logic [31:0] pc, input logic [31:0] val,
                              output logic [1:0] hnd, output logic [31:0] tgt);
        int lv;
        hnd = 2'd3;
        if (mpv != 2'd3 && md) hnd = 2'd1;
        if (mpv == 2'd0 && sd) hnd = 2'd0;
        lv = (hnd == 2'd0) ? 0 : (hnd == 2'd1) ? 1 : 2;
        mc[lv] = {irq, 26'd0, code};
        me[lv] = pc;
        mt[lv] = val;
        case (hnd)
            2'd0: begin mst[3] = mst[0]; mst[0] = 1'b0; end
            2'd1: begin mst[6] = mpv[0]; mst[4] = mst[1]; mst[1] = 1'b0; end
            default: begin mst[8:7] = mpv; mst[5] = mst[2]; mst[2] = 1'b0; end
        endcase
        tgt = ((lv == 0) ? UBASE : (lv == 1) ? SBASE : MBASE) & ~32'h3;
        mpv = hnd;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step();
        step();
        model_reset();
        // R10 state while held
        check_state("R10", "R10", "R10", 1'b1, RST_PC);
        rst_n = 1'b1;
        #1;
        chk("R10 boot redirect valid", redirect_valid, 1'b1);
        chk("R10 boot redirect pc", redirect_pc, RST_PC);
    endtask

    initial begin
        logic [1:0]  hnd;
        logic [31:0] tgt;
        logic [1:0]  privs [3];
        logic [9:0]  pats [2];
        int          n;
        privs[0] = 2'd0; privs[1] = 2'd1; privs[2] = 2'd3;
        pats[0]  = 10'h3B7;
        pats[1]  = 10'h0C8;
        trap_req = 1'b0; trap_code = '0; trap_is_irq = 1'b0;
        trap_pc = '0; trap_val = '0; mach_deleg = '0; sup_deleg = '0;
        ctx_load = 1'b0; ctx_priv = '0; ctx_status = '0;
        n = 0;
        do_reset();

        for (int p = 0; p < 3; p++) begin
            for (int md = 0; md < 2; md++) begin
                for (int sd = 0; sd < 2; sd++) begin
                    for (int irq = 0; irq < 2; irq++) begin
                        for (int sp = 0; sp < 2; sp++) begin
                            logic [4:0] code;
                            code = 5'((n * 7 + 3) % 32);
                            // R12 context load
                            ctx_load = 1'b1; ctx_priv = privs[p]; ctx_status = pats[sp];
                            step();
                            ctx_load = 1'b0;
                            mpv = privs[p]; mst = pats[sp];
                            check_state("R12", "R12", "R4", 1'b0, '0);
                            // R1 R2 trap with indexed mask bit, complement elsewhere
                            trap_req    = 1'b1;
                            trap_code   = code;
                            trap_is_irq = irq[0];
                            trap_pc     = 32'h1000_0000 + 32'(n * 4);
                            trap_val    = 32'hA5A5_0000 ^ 32'(n);
                            mach_deleg  = md[0] ? (32'h1 << code) : ~(32'h1 << code);
                            sup_deleg   = sd[0] ? (32'h1 << code) : ~(32'h1 << code);
                            model_trap(md[0], sd[0], code, irq[0], trap_pc, trap_val, hnd, tgt);
                            step();
                            check_state("R1 R2 R8",
                                        (hnd == 2'd0) ? "R5" : (hnd == 2'd1) ? "R6" : "R7",
                                        "R3 R4", 1'b1, tgt);
                            // R11 request during the redirect cycle
                            trap_code = code ^ 5'h11;
                            trap_pc   = 32'hDEAD_0000;
                            trap_val  = 32'hBEEF_0000;
                            step();
                            trap_req = 1'b0;
                            check_state("R11", "R11", "R11", 1'b0, '0);
                            n++;
                        end
                    end
                end
            end
        end

        // R12 reserved privilege value leaves privilege unchanged
        ctx_load = 1'b1; ctx_priv = 2'd1; ctx_status = 10'h155;
        step();
        mpv = 2'd1; mst = 10'h155;
        ctx_priv = 2'd2; ctx_status = 10'h2AA;
        step();
        ctx_load = 1'b0;
        mst = 10'h2AA;
        check_state("R12 reserved", "R12", "R12", 1'b0, '0);

        // R12 trap and load on the same edge: trap wins
        ctx_load = 1'b1; ctx_priv = 2'd0; ctx_status = 10'h3FF;
        trap_req = 1'b1; trap_code = 5'd9; trap_is_irq = 1'b1;
        trap_pc = 32'h0BAD_F00C; trap_val = 32'h1234_5678;
        mach_deleg = 32'h0; sup_deleg = 32'h0;
        model_trap(1'b0, 1'b0, 5'd9, 1'b1, trap_pc, trap_val, hnd, tgt);
        step();
        ctx_load = 1'b0; trap_req = 1'b0;
        check_state("R12 trap wins", "R12 R7", "R3 R4", 1'b1, tgt);
        step();

        // R10 reset with mprv and mie set
        ctx_load = 1'b1; ctx_priv = 2'd0; ctx_status = 10'h3FF;
        step();
        ctx_load = 1'b0;
        do_reset();
        step();
        check_state("R10", "R10", "R10", 1'b0, '0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule